// File: doc/BRIEF.md
# Shared-Control Configurable Register Bank

This block is a bank of single-bit storage cells that share one clock, one clock enable and one set/reset input. Each cell has its own data bit in and out, its own forced value for set/reset and its own power-up value. It stands in for the storage stage of a programmable-logic cell group. All options are fixed by parameters at elaboration time, so a given build has a single behaviour.

The set/reset style is chosen once for the whole bank: ignored, synchronous, or asynchronous. Each cell then gets its own polarity for that action: a 1 in `SR_VAL` makes it a set and a 0 makes it a reset. `INIT_VAL` gives the value that the global-initialize input loads. It defaults to `SR_VAL` but can be set on its own. The active clock edge can be inverted with a parameter, so no gate is placed in the clock path. Among the lowest `N_LATCH` cells, each one can be built as a level-sensitive latch. The clock then acts as the latch gate.

There is no data stream in this block. Every pin is a plain control or data level, and the interface has no valid/ready handshake and no back-pressure.

Top module: `srbank`

## Requirements
- R1: While `ginit` is 1, every `q[i]` equals `INIT_VAL[i]`. This takes effect at once, without a clock edge, and overrides clock, `ce`, `sr` and `d`.
- R2: A flip-flop cell loads `d[i]` on the active clock edge when `ce` is 1 and no set/reset action applies. The active edge is the rising edge of `clk` when `CLK_INV` is 0 and the falling edge when `CLK_INV` is 1.
- R3: A flip-flop cell keeps its value across an active edge when `ce` is 0 and no set/reset action applies.
- R4: With `SR_MODE` = 1 (synchronous), `sr` = 1 at an active edge loads `SR_VAL[i]` into every flip-flop cell, even when `ce` is 0. An `sr` pulse between edges does not change a flip-flop cell.
- R5: With `SR_MODE` = 2 (asynchronous), `sr` = 1 drives every cell to `SR_VAL[i]` at once, without a clock edge. Cells keep that value after `sr` falls, until a load or hold takes effect.
- R6: With `SR_MODE` = 0 (none), `sr` has no effect on any cell.
- R7: A cell `i` < `N_LATCH` with `LATCH_MASK[i]` = 1 is a latch. Its gate is active while `clk` is 1 (when `CLK_INV` is 0) or while `clk` is 0 (when `CLK_INV` is 1). The latch is transparent to `d[i]` while the gate is active and `ce` is 1, and holds its value otherwise.
- R8: In synchronous mode, a latch cell takes `SR_VAL[i]` while `sr` is 1 and its gate is active, whatever `ce` is. While the gate is inactive, `sr` has no effect on it.
- R9: `INIT_VAL` and `SR_VAL` are independent per cell. A cell may power up at 0 and be set to 1 by `sr`, or the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; latch gate for latch cells |
| ce | input | 1 | Shared clock enable, active high |
| sr | input | 1 | Shared set/reset, active high |
| ginit | input | 1 | Global initialize, asynchronous, highest priority |
| d | input | N_ELEM | Per-cell data in |
| q | output | N_ELEM | Per-cell data out |

## Verification
On every active edge, the bound assertions check the flip-flop cells: the initial-value override, loading under enable, holding without enable, the synchronous forced load, and the asynchronous forced value. At each gate closing, they also check that latch cells have followed their data. Other behaviour shows only in the bench's scenarios, which run six builds side by side covering every mode and both clock polarities. These scenarios cover an `sr` assertion between clock edges, the difference between latch and flip-flop cells under an `sr` pulse, values held after `sr` is released, and the mix of set and reset polarities within one bank.

// File: rtl/srbank_pkg.sv
package srbank_pkg;
  typedef enum logic [1:0] {
    SRM_NONE  = 2'd0,
    SRM_SYNC  = 2'd1,
    SRM_ASYNC = 2'd2
  } srmode_e;
endpackage

// File: rtl/srbank_ctl.sv
// Shared control decode: folds clock polarity into the active-high clock/gate
// and splits the shared set/reset into its level and gated flavours.
module srbank_ctl
  import srbank_pkg::*;
#(
  parameter srmode_e SR_MODE = SRM_SYNC,
  parameter bit      CLK_INV = 1'b0
) (
  input  logic clk,
  input  logic sr,
  output logic ck_act,
  output logic sr_lvl,
  output logic sr_gated
);
  localparam bit IS_ASYNC = (SR_MODE == SRM_ASYNC);
  localparam bit IS_SYNC  = (SR_MODE == SRM_SYNC);

  // Polarity is a constant; the xor folds away into the clock network.
  assign ck_act   = clk ^ CLK_INV;
  assign sr_lvl   = IS_ASYNC & sr;
  assign sr_gated = IS_SYNC & sr & ck_act;
endmodule

// File: rtl/srbank_ff.sv
// Edge-triggered cell; the set/reset flavour is picked at elaboration.
module srbank_ff
  import srbank_pkg::*;
#(
  parameter srmode_e SR_MODE = SRM_SYNC,
  parameter bit      SRV     = 1'b0,
  parameter bit      INITV   = 1'b0
) (
  input  logic ck,
  input  logic ce,
  input  logic sr,
  input  logic ginit,
  input  logic d,
  output logic q
);
  generate
    if (SR_MODE == SRM_ASYNC) begin : g_async
      always_ff @(posedge ck or posedge ginit or posedge sr) begin
        if (ginit)   q <= INITV;
        else if (sr) q <= SRV;
        else if (ce) q <= d;
      end
    end else begin : g_sync
      localparam bit USE_SR = (SR_MODE == SRM_SYNC);
      always_ff @(posedge ck or posedge ginit) begin
        if (ginit)             q <= INITV;
        else if (USE_SR && sr) q <= SRV;
        else if (ce)           q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/srbank_latch.sv
// Level-sensitive cell; gate is the polarity-corrected clock.
module srbank_latch #(
  parameter bit SRV   = 1'b0,
  parameter bit INITV = 1'b0
) (
  input  logic gate,
  input  logic ce,
  input  logic sr_lvl,
  input  logic sr_gated,
  input  logic ginit,
  input  logic d,
  output logic q
);
  always_latch begin
    if (ginit)            q <= INITV;
    else if (sr_lvl)      q <= SRV;
    else if (sr_gated)    q <= SRV;
    else if (gate && ce)  q <= d;
  end
endmodule

// File: rtl/srbank.sv
module srbank
  import srbank_pkg::*;
#(
  parameter int                N_ELEM     = 8,
  parameter int                N_LATCH    = 4,
  parameter srmode_e           SR_MODE    = SRM_SYNC,
  parameter bit                CLK_INV    = 1'b0,
  parameter logic [N_ELEM-1:0] SR_VAL     = '0,
  parameter logic [N_ELEM-1:0] INIT_VAL   = SR_VAL,
  parameter logic [N_LATCH-1:0] LATCH_MASK = '0
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              sr,
  input  logic              ginit,
  input  logic [N_ELEM-1:0] d,
  output logic [N_ELEM-1:0] q
);
  localparam logic [N_ELEM-1:0] LM_FULL = N_ELEM'(LATCH_MASK);

  logic ck_act, sr_lvl, sr_gated;

  srbank_ctl #(.SR_MODE(SR_MODE), .CLK_INV(CLK_INV)) u_ctl (
    .clk(clk), .sr(sr), .ck_act(ck_act), .sr_lvl(sr_lvl), .sr_gated(sr_gated)
  );

  generate
    for (genvar i = 0; i < N_ELEM; i++) begin : g_cell
      if (LM_FULL[i]) begin : g_lat
        srbank_latch #(.SRV(SR_VAL[i]), .INITV(INIT_VAL[i])) u_lat (
          .gate(ck_act), .ce(ce), .sr_lvl(sr_lvl), .sr_gated(sr_gated),
          .ginit(ginit), .d(d[i]), .q(q[i])
        );
      end else begin : g_reg
        srbank_ff #(.SR_MODE(SR_MODE), .SRV(SR_VAL[i]), .INITV(INIT_VAL[i])) u_ff (
          .ck(ck_act), .ce(ce), .sr(sr), .ginit(ginit), .d(d[i]), .q(q[i])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/srbank_chk.sv
module srbank_chk
  import srbank_pkg::*;
#(
  parameter int                 N_ELEM     = 8,
  parameter int                 N_LATCH    = 4,
  parameter srmode_e            SR_MODE    = SRM_SYNC,
  parameter bit                 CLK_INV    = 1'b0,
  parameter logic [N_ELEM-1:0]  SR_VAL     = '0,
  parameter logic [N_ELEM-1:0]  INIT_VAL   = SR_VAL,
  parameter logic [N_LATCH-1:0] LATCH_MASK = '0
) (
  input logic              clk,
  input logic              ce,
  input logic              sr,
  input logic              ginit,
  input logic [N_ELEM-1:0] d,
  input logic [N_ELEM-1:0] q
);
  localparam logic [N_ELEM-1:0] LMK = N_ELEM'(LATCH_MASK);
  localparam logic [N_ELEM-1:0] FFM = ~LMK;
  localparam bit SR_ON = (SR_MODE != SRM_NONE);

  logic ck;
  assign ck = clk ^ CLK_INV;

  assert_init_load_R1: assert property (@(posedge ck)
    ginit |-> (q == INIT_VAL));

  generate
    if (SR_MODE != SRM_ASYNC) begin : g_edge
      assert_ff_load_R2: assert property (@(posedge ck) disable iff (ginit)
        (ce && !(SR_ON && sr)) |=> ((q & FFM) == ($past(d) & FFM)));
      assert_ff_hold_R3: assert property (@(posedge ck) disable iff (ginit)
        (!ce && !(SR_ON && sr)) |=> $stable(q & FFM));
      assert_latch_follow_R7: assert property (@(negedge ck) disable iff (ginit)
        (ce && !(SR_ON && sr)) |-> ((q & LMK) == (d & LMK)));
    end
    if (SR_MODE == SRM_SYNC) begin : g_sync
      assert_sync_force_R4: assert property (@(posedge ck) disable iff (ginit)
        sr |=> ((q & FFM) == (SR_VAL & FFM)));
    end
    if (SR_MODE == SRM_ASYNC) begin : g_async
      assert_async_force_R5: assert property (@(posedge ck) disable iff (ginit)
        (sr && !$past(ginit)) |-> (q == SR_VAL));
    end
    if (SR_MODE == SRM_NONE) begin : g_none
      assert_sr_ignored_R6: assert property (@(posedge ck) disable iff (ginit)
        (sr && !ce) |=> $stable(q & FFM));
    end
  endgenerate
endmodule

bind srbank srbank_chk #(
  .N_ELEM(N_ELEM), .N_LATCH(N_LATCH), .SR_MODE(SR_MODE), .CLK_INV(CLK_INV),
  .SR_VAL(SR_VAL), .INIT_VAL(INIT_VAL), .LATCH_MASK(LATCH_MASK)
) u_chk (
  .clk(clk), .ce(ce), .sr(sr), .ginit(ginit), .d(d), .q(q)
);

// File: tb/srbank_test.sv
`timescale 1ns/1ps
module srbank_test;
  import srbank_pkg::*;

  localparam int CLK_PERIOD = 12;
  localparam int Q = CLK_PERIOD / 4;
  localparam int NCFG = 6;
  localparam logic [7:0] SRV   = 8'b1010_0110;
  localparam logic [7:0] INITV = 8'b0101_0011;
  localparam logic [3:0] LMASK = 4'b0101;

  logic clk = 1'b0, ce = 1'b0, sr = 1'b0, ginit = 1'b0;
  logic [7:0] d = '0;
  logic [7:0] q_all [NCFG];
  logic [7:0] expv  [NCFG];
  int checks = 0, errors = 0;
  logic prev_gi = 1'b0;

  // cfg k: mode = k/2 (0 none, 1 sync, 2 async), clock inverted when k odd
  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    localparam srmode_e M = srmode_e'(k / 2);
    logic [7:0] q;
    srbank #(
      .N_ELEM(8), .N_LATCH(4), .SR_MODE(M), .CLK_INV((k % 2) == 1),
      .SR_VAL(SRV), .INIT_VAL(INITV), .LATCH_MASK(LMASK)
    ) uut (.clk(clk), .ce(ce), .sr(sr), .ginit(ginit), .d(d), .q(q));
    assign q_all[k] = q;
  end

  function automatic logic [7:0] next_val(int k, logic [7:0] cur, bit rose, bit fell);
    int  m     = k / 2;
    bit  inv   = (k % 2) == 1;
    bit  gate  = clk ^ inv;
    bit  act   = inv ? fell : rose;
    logic [7:0] r = cur;
    for (int i = 0; i < 8; i++) begin
      if (ginit) r[i] = INITV[i];
      else if (i < 4 && LMASK[i]) begin
        if (m == 2 && sr)              r[i] = SRV[i];
        else if (gate && m == 1 && sr) r[i] = SRV[i];
        else if (gate && ce)           r[i] = d[i];
      end else begin
        if (m == 2 && sr) r[i] = SRV[i];
        else if (act) begin
          if (m == 1 && sr) r[i] = SRV[i];
          else if (ce)      r[i] = d[i];
        end
      end
    end
    return r;
  endfunction

  task automatic update(bit rose, bit fell);
    for (int k = 0; k < NCFG; k++) expv[k] = next_val(k, expv[k], rose, fell);
  endtask

  task automatic check_all(string tag);
    for (int k = 0; k < NCFG; k++) begin
      checks++;
      if (q_all[k] !== expv[k]) begin
        errors++;
        $display("FAIL %s cfg%0d t=%0t: q=%b expected %b", tag, k, $time, q_all[k], expv[k]);
      end
    end
  endtask

  task automatic step(logic [7:0] dv, logic cev, logic srv, logic giv, string tag);
    d = dv; ce = cev; sr = srv; ginit = giv; prev_gi = giv;
    update(0, 0); #Q; check_all(tag);
    clk = 1'b1; update(1, 0); #Q; check_all(tag);
    #Q;
    clk = 1'b0; update(0, 1); #Q; check_all(tag);
  endtask

  // sr raised while the clock is high, between edges
  task automatic step_mid_sr(logic [7:0] dv, logic cev, string tag);
    d = dv; ce = cev; sr = 1'b0; ginit = 1'b0; prev_gi = 1'b0;
    update(0, 0); #Q; check_all(tag);
    clk = 1'b1; update(1, 0); #Q; check_all(tag);
    sr = 1'b1; update(0, 0); #1; check_all(tag);
    #(Q - 1);
    clk = 1'b0; update(0, 1); #Q; check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCFG; k++) expv[k] = '0;
    #1;
    // R1 R9: global initialize overrides sr, ce and clock
    step(8'hFF, 1'b1, 1'b1, 1'b1, "R1 R9");
    step(8'h00, 1'b0, 1'b0, 1'b1, "R1 R9");
    // R2 R7: load and transparency
    step(8'hC3, 1'b1, 1'b0, 1'b0, "R2 R7");
    step(8'h3C, 1'b1, 1'b0, 1'b0, "R2 R7");
    // R3: enable low holds
    step(8'h5A, 1'b0, 1'b0, 1'b0, "R3 R7");
    // R4 R5 R6 R8: sr with enable low
    step(8'h5A, 1'b0, 1'b1, 1'b0, "R4 R5 R6 R8");
    step(8'h0F, 1'b1, 1'b0, 1'b0, "R2 R5");
    step(8'hF0, 1'b0, 1'b0, 1'b0, "R3");
    // R5 R4 R8: sr raised between edges
    step_mid_sr(8'h99, 1'b0, "R5 R4 R8");
    step(8'h66, 1'b0, 1'b0, 1'b0, "R5 R6");
    step(8'h66, 1'b1, 1'b0, 1'b0, "R2");
    // R1: pulse of global initialize mid-run
    step(8'h11, 1'b1, 1'b0, 1'b1, "R1 R9");
    step(8'h22, 1'b1, 1'b0, 1'b0, "R2 R7");
    // random mix
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 400; n++) begin
      logic [7:0] dv  = 8'($urandom);
      logic cev = ($urandom % 3) != 0;
      logic srv = ($urandom % 4) == 0;
      logic giv = ($urandom % 16) == 0;
      if (prev_gi && !giv) srv = 1'b0;
      step(dv, cev, srv, giv, "R2 R3 R7 R8");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule